// File: doc/BRIEF.md
# Audio Sample Packet Assembler

This block sits between a fixed-rate audio sampler and the serializer that drives a shared wire. Every 8-bit unsigned sample that arrives with a strobe, nominally once every 0.5 ms, goes into a small on-chip FIFO. When the FIFO holds a full payload's worth of samples and no packet is already under way, the block starts a packet and requests the medium. It then waits for a grant. The FIFO keeps absorbing samples for as long as that wait lasts.

Once the grant arrives, the block sends one header byte followed by a fixed payload of samples. The bytes go out over a valid/ready byte stream, and a last flag marks the final byte. The header packs the control bits, the destination ID and the source ID, all captured when the packet starts. If a sample arrives while the FIFO is full, that sample is lost and a sticky flag records the loss.

Top module: `audio_pkt_assembler`

## Requirements
- R1: While reset is held low, `tx_valid`, `med_req`, `tx_last` and `smp_overflow` are all 0 from the first rising edge on.
- R2: A strobed sample is stored when the FIFO is not full, and payload bytes leave in the order their samples arrived.
- R3: A sample strobed while the FIFO holds DEPTH (default 16) samples is discarded. `smp_overflow` then reads 1 from the next cycle and stays 1 until reset.
- R4: If no packet is in progress and the FIFO holds at least PAYLOAD (default 8) samples at a rising edge, `med_req` is 1 after that edge.
- R5: `tx_valid` stays 0 while a packet waits for the medium. The header byte is offered in the cycle after a rising edge at which `med_grant` was 1 during that wait.
- R6: The header byte is {mode[1:0], dst_id[2:0], src_id[2:0]}, with bits 7:6 as control, 5:3 as destination and 2:0 as source. It is captured at the edge where the packet starts, so mode 00 gives 00 in bits 7:6.
- R7: A packet is the header plus exactly PAYLOAD sample bytes. `tx_last` is 1 only on the final payload byte.
- R8: While `tx_valid` is 1 and `tx_ready` is 0, `tx_data` and `tx_last` hold their values. A FIFO sample is consumed only when its byte is accepted.
- R9: `med_req` stays 1 from packet start until the last byte is accepted and falls after that edge. No new packet starts while one is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 8 | Unsigned audio sample |
| src_id | input | 3 | Own station ID (header source field) |
| dst_id | input | 3 | Destination station ID |
| mode | input | 2 | Control bits placed in the header |
| med_req | output | 1 | Packet pending or in flight; medium requested |
| med_grant | input | 1 | Medium granted by the access logic |
| tx_data | output | 8 | Byte toward the serializer |
| tx_valid | output | 1 | `tx_data` is offered |
| tx_ready | input | 1 | Serializer accepts the byte |
| tx_last | output | 1 | Offered byte ends the packet |
| smp_overflow | output | 1 | Sticky: a sample was dropped on a full FIFO |

## Verification
A stored sample counts toward the fill level one edge after its strobe, and `med_req` rises one edge after the level reaches the payload size. The header follows one edge after a sampled grant, and `smp_overflow` follows one edge after a dropped strobe. Each byte leaves on the edge where it is accepted. The bench changes inputs 1 ns after each rising edge and samples outputs at the falling edge. At that point it compares the outputs with a cycle model that applies exactly one register stage per result. It then advances the model with the inputs that the next rising edge will see.

// File: rtl/apa_pkg.sv
// Package: shared types for the audio sample packet assembler.
// Assumes nothing beyond IEEE 1800-2017.
package apa_pkg;
    // Packet engine phases: idle, waiting for medium, header beat, payload beats.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HOLD = 2'd1,
        PH_HEAD = 2'd2,
        PH_BODY = 2'd3
    } apa_phase_e;
endpackage

// File: rtl/apa_sample_fifo.sv
// Module: apa_sample_fifo
// Circular sample buffer with occupancy count and a sticky drop flag.
// Assumes DEPTH is a power of two; a write on a full buffer is dropped
// even if a read happens in the same cycle.
module apa_sample_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_en,
    output logic [W-1:0]  rd_data,
    output logic [CW-1:0] count,
    output logic          overflow
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          full;
    logic          do_wr;
    logic          do_rd;

    // Derive full and the gated write/read enables.
    always_comb begin
        full  = (count == CW'(DEPTH));
        do_wr = wr_en && !full;
        do_rd = rd_en && (count != '0);
    end

    // Store accepted samples at the write pointer.
    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    // Advance pointers and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) wr_ptr <= wr_ptr + 1'b1;
            if (do_rd) rd_ptr <= rd_ptr + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Latch the drop flag until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overflow <= 1'b0;
        end else if (wr_en && full) begin
            overflow <= 1'b1;
        end
    end

    // Head of buffer is always presented.
    assign rd_data = mem[rd_ptr];

    // A strobe on a full buffer keeps occupancy from growing and raises the flag.
    assert_drop_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full) |=> (overflow && count <= $past(count)));

    // The drop flag never clears outside reset.
    assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // A read request never arrives on an empty buffer.
    assert_no_underrun_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (count != '0));
endmodule

// File: rtl/apa_hdr_pack.sv
// Module: apa_hdr_pack
// Forms the header byte from control bits and station IDs.
// Assumes the control field sits at the top, then destination, then source.
module apa_hdr_pack #(
    parameter int ID_W   = 3,
    parameter int CTRL_W = 2,
    localparam int HW    = CTRL_W + 2 * ID_W
) (
    input  logic [CTRL_W-1:0] ctrl,
    input  logic [ID_W-1:0]   dst,
    input  logic [ID_W-1:0]   src,
    output logic [HW-1:0]     hdr
);
    // Concatenate fields MSB first: control, destination, source.
    always_comb begin
        hdr = {ctrl, dst, src};
    end
endmodule

// File: rtl/apa_pkt_framer.sv
// Module: apa_pkt_framer
// Starts a packet once a full payload is buffered, waits for the medium
// grant, then emits the header and PAYLOAD bytes on a valid/ready stream.
// Assumes it is the only reader of the FIFO, so a started packet always
// finds its payload present.
module apa_pkt_framer
    import apa_pkg::*;
#(
    parameter int W       = 8,
    parameter int PAYLOAD = 8,
    parameter int CW      = 5,
    localparam int BW     = (PAYLOAD > 1) ? $clog2(PAYLOAD) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] fifo_count,
    input  logic [W-1:0]  fifo_data,
    input  logic [W-1:0]  hdr_in,
    input  logic          med_grant,
    input  logic          tx_ready,
    output logic          med_req,
    output logic          fifo_pop,
    output logic [W-1:0]  tx_data,
    output logic          tx_valid,
    output logic          tx_last
);
    apa_phase_e    phase;
    logic [BW-1:0] beat;
    logic [W-1:0]  hdr_q;
    logic          body_end;

    // Flag the final payload beat.
    always_comb begin
        body_end = (phase == PH_BODY) && (beat == BW'(PAYLOAD - 1));
    end

    // Phase sequencing, beat counting and header capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            beat  <= '0;
            hdr_q <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (fifo_count >= CW'(PAYLOAD)) begin
                        hdr_q <= hdr_in;
                        phase <= PH_HOLD;
                    end
                end
                PH_HOLD: begin
                    if (med_grant) phase <= PH_HEAD;
                end
                PH_HEAD: begin
                    if (tx_ready) begin
                        phase <= PH_BODY;
                        beat  <= '0;
                    end
                end
                PH_BODY: begin
                    if (tx_ready) begin
                        if (body_end) phase <= PH_IDLE;
                        else          beat  <= beat + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Drive stream outputs, request and FIFO pop from the phase.
    always_comb begin
        med_req  = (phase != PH_IDLE);
        tx_valid = (phase == PH_HEAD) || (phase == PH_BODY);
        tx_data  = (phase == PH_HEAD) ? hdr_q : fifo_data;
        tx_last  = body_end;
        fifo_pop = (phase == PH_BODY) && tx_ready;
    end

    // An offered byte that is not taken is held unchanged.
    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    // The request covers every offered byte.
    assert_valid_has_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> med_req);

    // Accepting the last byte releases the medium.
    assert_last_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_last) |=> !med_req);

    // An idle engine with a full payload buffered starts a packet.
    assert_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!med_req && fifo_count >= CW'(PAYLOAD)) |=> med_req);

    // No byte goes out before a grant has been seen.
    assert_wait_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (med_req && !tx_valid && !med_grant) |=> !tx_valid);
endmodule

// File: rtl/audio_pkt_assembler.sv
// Module: audio_pkt_assembler (top)
// Buffers strobed audio samples and sends them as header-plus-payload
// packets once the shared medium is granted.
// Assumes DEPTH is a power of two and DEPTH >= PAYLOAD.
module audio_pkt_assembler #(
    parameter int SMP_W   = 8,
    parameter int ID_W    = 3,
    parameter int CTRL_W  = 2,
    parameter int DEPTH   = 16,
    parameter int PAYLOAD = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [SMP_W-1:0]  smp_data,
    input  logic [ID_W-1:0]   src_id,
    input  logic [ID_W-1:0]   dst_id,
    input  logic [CTRL_W-1:0] mode,
    output logic              med_req,
    input  logic              med_grant,
    output logic [SMP_W-1:0]  tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic              tx_last,
    output logic              smp_overflow
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0]    fifo_count;
    logic [SMP_W-1:0] fifo_data;
    logic             fifo_pop;
    logic [SMP_W-1:0] hdr_byte;

    apa_sample_fifo #(
        .W     (SMP_W),
        .DEPTH (DEPTH)
    ) fifo_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (smp_valid),
        .wr_data  (smp_data),
        .rd_en    (fifo_pop),
        .rd_data  (fifo_data),
        .count    (fifo_count),
        .overflow (smp_overflow)
    );

    apa_hdr_pack #(
        .ID_W   (ID_W),
        .CTRL_W (CTRL_W)
    ) hdr_i (
        .ctrl (mode),
        .dst  (dst_id),
        .src  (src_id),
        .hdr  (hdr_byte)
    );

    apa_pkt_framer #(
        .W       (SMP_W),
        .PAYLOAD (PAYLOAD),
        .CW      (CW)
    ) framer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_count (fifo_count),
        .fifo_data  (fifo_data),
        .hdr_in     (hdr_byte),
        .med_grant  (med_grant),
        .tx_ready   (tx_ready),
        .med_req    (med_req),
        .fifo_pop   (fifo_pop),
        .tx_data    (tx_data),
        .tx_valid   (tx_valid),
        .tx_last    (tx_last)
    );

    // Header field layout must match the byte width.
    initial begin
        assert_hdr_width_R6: assert (CTRL_W + 2 * ID_W == SMP_W);
    end
endmodule

// File: tb/audio_pkt_assembler_tb.sv
// Bench: audio_pkt_assembler_tb_top
// Drives inputs 1 ns after each rising edge, checks outputs at the falling
// edge against a cycle model, then advances the model to the next edge.
module audio_pkt_assembler_tb_top;
    localparam int DEPTH   = 16;
    localparam int PAYLOAD = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_valid = 1'b0;
    logic [7:0] smp_data = '0;
    logic [2:0] src_id = '0;
    logic [2:0] dst_id = '0;
    logic [1:0] mode = '0;
    logic       med_req;
    logic       med_grant = 1'b0;
    logic [7:0] tx_data;
    logic       tx_valid;
    logic       tx_ready = 1'b0;
    logic       tx_last;
    logic       smp_overflow;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    audio_pkt_assembler dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .smp_valid    (smp_valid),
        .smp_data     (smp_data),
        .src_id       (src_id),
        .dst_id       (dst_id),
        .mode         (mode),
        .med_req      (med_req),
        .med_grant    (med_grant),
        .tx_data      (tx_data),
        .tx_valid     (tx_valid),
        .tx_ready     (tx_ready),
        .tx_last      (tx_last),
        .smp_overflow (smp_overflow)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_hdr(input logic [1:0] m, input logic [2:0] d,
                                           input logic [2:0] s);
        return {m, d, s};
    endfunction

    // Cycle model state.
    int         m_cnt;
    bit         m_ovf;
    int         m_phase;   // 0 idle, 1 waiting for grant, 2 sending
    int         m_beat;    // 0 header, 1..PAYLOAD payload
    logic [7:0] m_hdr;
    logic [7:0] m_q[$];
    bit         held;
    logic [7:0] held_data;

    always @(negedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_ovf = 0; m_phase = 0; m_beat = 0; m_hdr = '0; held = 0;
            m_q.delete();
            if (!done) begin
                chk(!tx_valid && !med_req && !tx_last && !smp_overflow, "R1",
                    {tx_valid, med_req, tx_last, smp_overflow}, 0);
            end
        end else begin
            bit push;
            bit drop;
            bit pop;
            chk(med_req == (m_phase != 0), (m_phase == 2) ? "R9" : "R4",
                int'(med_req), int'(m_phase != 0));
            chk(tx_valid == (m_phase == 2), "R5", int'(tx_valid), int'(m_phase == 2));
            chk(smp_overflow == m_ovf, "R3", int'(smp_overflow), int'(m_ovf));
            if (m_phase == 2 && tx_valid) begin
                if (m_beat == 0)
                    chk(tx_data == m_hdr, "R6", tx_data, m_hdr);
                else
                    chk(tx_data == m_q[0], "R2", tx_data, m_q[0]);
                chk(tx_last == (m_beat == PAYLOAD), "R7", int'(tx_last), int'(m_beat == PAYLOAD));
                if (held) chk(tx_data == held_data, "R8", tx_data, held_data);
            end
            held = tx_valid && !tx_ready;
            held_data = tx_data;
            // Advance the model to the next rising edge.
            push = smp_valid && (m_cnt < DEPTH);
            drop = smp_valid && (m_cnt == DEPTH);
            pop = 0;
            case (m_phase)
                0: if (m_cnt >= PAYLOAD) begin
                       m_hdr = exp_hdr(mode, dst_id, src_id);
                       m_phase = 1;
                   end
                1: if (med_grant) begin
                       m_phase = 2;
                       m_beat = 0;
                   end
                default: if (tx_ready) begin
                       if (m_beat >= 1) pop = 1;
                       if (m_beat == PAYLOAD) m_phase = 0;
                       else m_beat++;
                   end
            endcase
            if (pop) void'(m_q.pop_front());
            if (push) m_q.push_back(smp_data);
            m_cnt = m_cnt + int'(push) - int'(pop);
            if (drop) m_ovf = 1;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        void'($urandom(32'd4242));
        // R1: reset state.
        repeat (3) tick();
        rst_n = 1'b1;
        // Directed: fill past DEPTH without a grant, mode 00 header (R3, R5, R6).
        tx_ready = 1'b1;
        mode = 2'b00; dst_id = 3'd5; src_id = 3'd2;
        for (int i = 0; i < DEPTH + 4; i++) begin
            smp_valid = 1'b1;
            smp_data = 8'(i * 7 + 1);
            tick();
        end
        smp_valid = 1'b0;
        repeat (6) tick();
        // Directed: single-cycle grant, then a stalled stream (R5, R8, R7).
        med_grant = 1'b1;
        tick();
        med_grant = 1'b0;
        tx_ready = 1'b0;
        repeat (3) tick();
        for (int i = 0; i < 30; i++) begin
            tx_ready = (i % 3 != 0);
            tick();
        end
        med_grant = 1'b1;
        tx_ready = 1'b1;
        repeat (20) tick();
        // Constrained random traffic (R2, R4, R6, R7, R8, R9).
        for (int i = 0; i < 3000; i++) begin
            smp_valid = ($urandom % 4 == 0);
            smp_data = 8'($urandom);
            if ($urandom % 8 == 0) begin
                src_id = 3'($urandom);
                dst_id = 3'($urandom);
                mode = 2'($urandom);
            end
            med_grant = ($urandom % 3 != 0);
            tx_ready = ($urandom % 4 != 0);
            tick();
        end
        // Burst with slow drain to force a second drop (R3 sticky).
        med_grant = 1'b0;
        for (int i = 0; i < DEPTH + 2; i++) begin
            smp_valid = 1'b1;
            smp_data = 8'($urandom);
            tick();
        end
        smp_valid = 1'b0;
        med_grant = 1'b1;
        repeat (40) tick();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule